// File: doc/BRIEF.md
# Segmented Memory Operand Address Generator

This block turns the addressing fields of a decoded instruction into a memory address for a 16-bit segmented processor. Given the two-bit mode field, the three-bit register/memory field, a displacement, the four pointer registers (BX, BP, SI, DI) and the four segment registers, it forms the 16-bit offset within a segment, chooses which segment that offset lives in, and combines the two into a 20-bit physical address.

An optional segment-override prefix code replaces the default segment choice. A mode value of 11 means the operand is a register, not memory, and the block marks the result as not a memory access. All results appear on registered outputs one clock after an input strobe. Fetching instruction bytes and performing the memory access happen outside this block.

Top module: `seg_ea_gen`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `out_valid`, `out_is_mem`, `out_ea`, `out_seg` and `out_pa` are all zero.
- R2: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. In a cycle with `in_valid` low, the other outputs keep their previous values whatever the inputs do.
- R3: For mode 00, 01 or 10, the r/m field selects the address terms: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX.
- R4: Mode 00 adds no displacement. Mode 01 adds `disp[7:0]` sign-extended to 16 bits. Mode 10 adds all 16 bits of `disp`.
- R5: Mode 00 with r/m 110 is direct addressing. The offset is `disp` alone, BP is not read, and the default segment is DS.
- R6: With no valid override, the segment is SS when BP is one of the address terms and DS otherwise.
- R7: With `ovr_valid` high, the codes 8'h26, 8'h2E, 8'h36 and 8'h3E force ES, CS, SS and DS respectively. Any other code value leaves the default choice in place. `out_seg` encodes ES=0, CS=1, SS=2, DS=3.
- R8: `out_pa` equals the selected segment register's value times 16, plus `out_ea`, taken modulo 2^20.
- R9: Mode 11 gives `out_is_mem`=0, and `out_ea`, `out_seg` and `out_pa` are all zero. Any memory mode gives `out_is_mem`=1.
- R10: The offset sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| mod_f | input | 2 | Addressing mode field |
| rm_f | input | 3 | Register/memory field |
| disp | input | 16 | Displacement (low byte used in mode 01) |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_valid | input | 1 | An override prefix is present |
| ovr_code | input | 8 | Override prefix byte |
| out_valid | output | 1 | Results valid |
| out_is_mem | output | 1 | Operand is in memory |
| out_ea | output | 16 | Effective offset |
| out_seg | output | 2 | Selected segment (ES=0, CS=1, SS=2, DS=3) |
| out_pa | output | 20 | Physical address |

## Verification
The default segment choice and the override can both act on the same operand. The case that matters most is a BP-based form that defaults to SS arriving with an override prefix, so the two decisions have to be resolved in one cycle. The sweep runs every mode and r/m pair against no override, each of the four legal prefix codes, and one illegal code. For every combination it compares the segment and the physical address against an arithmetic model. This covers the direct form, which would default to SS if the BP rule were applied naively, and register mode, where an override must have no visible effect.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_sel_e;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [1:0] MODE_DISP16 = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;

  localparam logic [2:0] RM_DIRECT   = 3'b110;
endpackage

// File: rtl/ea_term_sel.sv
module ea_term_sel #(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [1:0]        mod_f,
  input  logic [2:0]        rm_f,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] reg_bx,
  input  logic [ADDR_W-1:0] reg_bp,
  input  logic [ADDR_W-1:0] reg_si,
  input  logic [ADDR_W-1:0] reg_di,
  output logic [ADDR_W-1:0] ea,
  output logic              uses_bp,
  output logic              is_mem
);
  import seg_ea_pkg::*;

  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] base_t, index_t, disp_t;
  logic              direct;

  assign direct = (mod_f == MODE_NODISP) && (rm_f == RM_DIRECT);
  assign is_mem = (mod_f != MODE_REG);

  always_comb begin
    base_t  = '0;
    index_t = '0;
    uses_bp = 1'b0;
    unique case (rm_f)
      3'b000: begin base_t = reg_bx; index_t = reg_si; end
      3'b001: begin base_t = reg_bx; index_t = reg_di; end
      3'b010: begin base_t = reg_bp; index_t = reg_si; uses_bp = 1'b1; end
      3'b011: begin base_t = reg_bp; index_t = reg_di; uses_bp = 1'b1; end
      3'b100: index_t = reg_si;
      3'b101: index_t = reg_di;
      3'b110: begin
        if (!direct) begin
          base_t  = reg_bp;
          uses_bp = 1'b1;
        end
      end
      default: base_t = reg_bx;
    endcase
    if (!is_mem) uses_bp = 1'b0;
  end

  always_comb begin
    unique case (mod_f)
      MODE_DISP8:  disp_t = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
      MODE_DISP16: disp_t = disp;
      default:     disp_t = direct ? disp : '0;
    endcase
  end

  assign ea = is_mem ? (base_t + index_t + disp_t) : '0;
endmodule

// File: rtl/seg_pick.sv
module seg_pick (
  input  logic                 uses_bp,
  input  logic                 ovr_valid,
  input  logic [7:0]           ovr_code,
  output seg_ea_pkg::seg_sel_e seg
);
  import seg_ea_pkg::*;

  logic legal;

  // prefix bytes have the shape 001s_s110, ss naming the segment
  assign legal = ovr_valid && (ovr_code[7:5] == 3'b001) && (ovr_code[2:0] == 3'b110);

  always_comb begin
    if (legal)        seg = seg_sel_e'(ovr_code[4:3]);
    else if (uses_bp) seg = SEG_SS;
    else              seg = SEG_DS;
  end
endmodule

// File: rtl/pa_form.sv
module pa_form #(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NSEG      = 4,
  localparam int PA_W     = ADDR_W + SEG_SHIFT,
  localparam int SEL_W    = $clog2(NSEG)
) (
  input  logic [NSEG-1:0][ADDR_W-1:0] segs,
  input  logic [SEL_W-1:0]            sel,
  input  logic [ADDR_W-1:0]           ea,
  output logic [PA_W-1:0]             pa
);
  logic [NSEG-1:0][PA_W-1:0] cand;

  for (genvar g = 0; g < NSEG; g++) begin : g_cand
    assign cand[g] = {segs[g], {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea};
  end

  assign pa = cand[sel];
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen #(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8,
  localparam int PA_W     = ADDR_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mod_f,
  input  logic [2:0]        rm_f,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] reg_bx,
  input  logic [ADDR_W-1:0] reg_bp,
  input  logic [ADDR_W-1:0] reg_si,
  input  logic [ADDR_W-1:0] reg_di,
  input  logic [ADDR_W-1:0] seg_es,
  input  logic [ADDR_W-1:0] seg_cs,
  input  logic [ADDR_W-1:0] seg_ss,
  input  logic [ADDR_W-1:0] seg_ds,
  input  logic              ovr_valid,
  input  logic [7:0]        ovr_code,
  output logic              out_valid,
  output logic              out_is_mem,
  output logic [ADDR_W-1:0] out_ea,
  output logic [1:0]        out_seg,
  output logic [PA_W-1:0]   out_pa
);
  import seg_ea_pkg::*;

  logic [ADDR_W-1:0]      ea_c;
  logic                   uses_bp_c, is_mem_c;
  seg_sel_e               seg_c;
  logic [PA_W-1:0]        pa_c;
  logic [3:0][ADDR_W-1:0] segs;

  assign segs = {seg_ds, seg_ss, seg_cs, seg_es};

  ea_term_sel #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_terms (
    .mod_f(mod_f), .rm_f(rm_f), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .ea(ea_c), .uses_bp(uses_bp_c), .is_mem(is_mem_c)
  );

  seg_pick u_seg (
    .uses_bp(uses_bp_c), .ovr_valid(ovr_valid), .ovr_code(ovr_code), .seg(seg_c)
  );

  pa_form #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT), .NSEG(4)) u_pa (
    .segs(segs), .sel(seg_c), .ea(ea_c), .pa(pa_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_is_mem <= 1'b0;
      out_ea     <= '0;
      out_seg    <= '0;
      out_pa     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_is_mem <= is_mem_c;
        out_ea     <= is_mem_c ? ea_c : '0;
        out_seg    <= is_mem_c ? seg_c : 2'd0;
        out_pa     <= is_mem_c ? pa_c : '0;
      end
    end
  end
endmodule

// File: rtl/seg_ea_chk.sv
module seg_ea_chk #(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = ADDR_W + SEG_SHIFT
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        mod_f,
  input logic [2:0]        rm_f,
  input logic [ADDR_W-1:0] disp,
  input logic [ADDR_W-1:0] seg_es,
  input logic [ADDR_W-1:0] seg_cs,
  input logic [ADDR_W-1:0] seg_ss,
  input logic [ADDR_W-1:0] seg_ds,
  input logic              ovr_valid,
  input logic [7:0]        ovr_code,
  input logic              out_valid,
  input logic              out_is_mem,
  input logic [ADDR_W-1:0] out_ea,
  input logic [1:0]        out_seg,
  input logic [PA_W-1:0]   out_pa
);
  function automatic logic [ADDR_W-1:0] pick(input logic [1:0] s, input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] c,
                                             input logic [ADDR_W-1:0] d);
    case (s)
      2'd0: pick = a;
      2'd1: pick = b;
      2'd2: pick = c;
      default: pick = d;
    endcase
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_ea) && $stable(out_pa) && $stable(out_seg))); // R2
  AST_REG_MODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_mem) |-> (out_ea == '0 && out_pa == '0 && out_seg == 2'd0)); // R9
  AST_PA_FROM_SEG: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_mem) |->
      out_pa == ({pick(out_seg, $past(seg_es), $past(seg_cs), $past(seg_ss), $past(seg_ds)),
                  {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, out_ea})); // R8
  AST_OVERRIDE_SS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mod_f != 2'b11 && ovr_valid && ovr_code == 8'h36) |=> out_seg == 2'd2); // R7
  AST_DIRECT_DISP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mod_f == 2'b00 && rm_f == 3'b110) |=> out_ea == $past(disp)); // R5
endmodule

bind seg_ea_gen seg_ea_chk #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_seg_ea_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mod_f(mod_f), .rm_f(rm_f), .disp(disp),
  .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
  .ovr_valid(ovr_valid), .ovr_code(ovr_code), .out_valid(out_valid),
  .out_is_mem(out_is_mem), .out_ea(out_ea), .out_seg(out_seg), .out_pa(out_pa)
);

// File: tb/test_seg_ea_gen.sv
module test_seg_ea_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mod_f = '0;
  logic [2:0]  rm_f = '0;
  logic [15:0] disp = '0, reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic        ovr_valid = 1'b0;
  logic [7:0]  ovr_code = '0;
  logic        out_valid, out_is_mem;
  logic [15:0] out_ea;
  logic [1:0]  out_seg;
  logic [19:0] out_pa;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  seg_ea_gen i_seg_ea_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mod_f(mod_f), .rm_f(rm_f), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_valid(ovr_valid), .ovr_code(ovr_code), .out_valid(out_valid),
    .out_is_mem(out_is_mem), .out_ea(out_ea), .out_seg(out_seg), .out_pa(out_pa)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (mod=%b rm=%b ovr=%b/%h)",
               req, act, exp, mod_f, rm_f, ovr_valid, ovr_code);
    end
  endtask

  task automatic set_pattern(input int p);
    case (p)
      0: begin reg_bx = 16'h1234; reg_bp = 16'h0F00; reg_si = 16'h0011; reg_di = 16'h00F0;
               disp = 16'h0085; seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000; end
      1: begin reg_bx = 16'hFFF0; reg_bp = 16'hFFFF; reg_si = 16'h8000; reg_di = 16'h0020;
               disp = 16'h7FFF; seg_es = 16'hF000; seg_cs = 16'hFFFF; seg_ss = 16'hABCD; seg_ds = 16'h0001; end
      default: begin reg_bx = 16'h0100; reg_bp = 16'h0200; reg_si = 16'h0003; reg_di = 16'h0040;
               disp = 16'h1234; seg_es = 16'h0ABC; seg_cs = 16'hFFF0; seg_ss = 16'h0010; seg_ds = 16'hC000; end
    endcase
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] e_ea, e_base, e_idx, e_disp, e_segv;
    logic [1:0]  e_seg;
    logic        e_bp, e_mem;
    logic [19:0] e_pa;
    logic [15:0] h_ea;
    logic [19:0] h_pa;
    logic [1:0]  h_seg;

    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 ea", {16'd0, out_ea}, 32'd0);
    check("R1 pa", {12'd0, out_pa}, 32'd0);
    check("R1 mem", {31'd0, out_is_mem}, 32'd0);

    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int r = 0; r < 8; r++) begin
          for (int ov = 0; ov < 6; ov++) begin
            set_pattern(p);
            mod_f = m[1:0];
            rm_f = r[2:0];
            ovr_valid = (ov != 0);
            case (ov)
              1: ovr_code = 8'h26;
              2: ovr_code = 8'h2E;
              3: ovr_code = 8'h36;
              4: ovr_code = 8'h3E;
              5: ovr_code = 8'h27;
              default: ovr_code = 8'h36;
            endcase
            in_valid = 1'b1;
            // model R3, R4, R5, R6, R7, R8, R10
            e_mem = (m != 3);
            e_base = 16'd0; e_idx = 16'd0; e_bp = 1'b0;
            case (r)
              0: begin e_base = reg_bx; e_idx = reg_si; end
              1: begin e_base = reg_bx; e_idx = reg_di; end
              2: begin e_base = reg_bp; e_idx = reg_si; e_bp = 1'b1; end
              3: begin e_base = reg_bp; e_idx = reg_di; e_bp = 1'b1; end
              4: e_idx = reg_si;
              5: e_idx = reg_di;
              6: if (m != 0) begin e_base = reg_bp; e_bp = 1'b1; end
              default: e_base = reg_bx;
            endcase
            if (m == 1) e_disp = {{8{disp[7]}}, disp[7:0]};
            else if (m == 2 || (m == 0 && r == 6)) e_disp = disp;
            else e_disp = 16'd0;
            e_ea = e_base + e_idx + e_disp;
            if (ov >= 1 && ov <= 4) e_seg = 2'(ov - 1);
            else e_seg = e_bp ? 2'd2 : 2'd3;
            case (e_seg)
              2'd0: e_segv = seg_es;
              2'd1: e_segv = seg_cs;
              2'd2: e_segv = seg_ss;
              default: e_segv = seg_ds;
            endcase
            e_pa = 20'((32'(e_segv) * 16 + 32'(e_ea)) % 32'h100000);
            if (!e_mem) begin e_ea = 16'd0; e_seg = 2'd0; e_pa = 20'd0; end
            @(negedge clk);
            check("R2 valid", {31'd0, out_valid}, 32'd1);
            check("R9 is_mem", {31'd0, out_is_mem}, {31'd0, e_mem});
            check("R3/R4/R5/R10 ea", {16'd0, out_ea}, {16'd0, e_ea});
            check("R6/R7 seg", {30'd0, out_seg}, {30'd0, e_seg});
            check("R8 pa", {12'd0, out_pa}, {12'd0, e_pa});
          end
        end
      end
      // R2 hold: in_valid low, change every input
      h_ea = out_ea; h_pa = out_pa; h_seg = out_seg;
      in_valid = 1'b0;
      set_pattern((p + 1) % 3);
      mod_f = 2'b10; rm_f = 3'b010; ovr_valid = 1'b1; ovr_code = 8'h26;
      @(negedge clk);
      check("R2 idle valid", {31'd0, out_valid}, 32'd0);
      check("R2 hold ea", {16'd0, out_ea}, {16'd0, h_ea});
      check("R2 hold pa", {12'd0, out_pa}, {12'd0, h_pa});
      check("R2 hold seg", {30'd0, out_seg}, {30'd0, h_seg});
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule